// File: doc/BRIEF.md
# CAN identifier acceptance filter

This block sits behind a CAN receiver and decides whether each received frame reaches the host. A frame comes in as a parallel 32-bit identifier, four bytes IDR0 to IDR3, with a frame-valid strobe and an extended-format bit. The frame is always copied into a background buffer. It is then compared against a number of filter banks. Each bank holds a 32-bit acceptance code and a 32-bit mask. When any bank matches, the frame is copied into the host-facing buffer, a receive-full flag is raised and a one-cycle accept pulse is produced. A rejected frame raises nothing and stays in the background buffer until the next frame overwrites it.

Codes and masks sit in a small byte-wide register file. It can be read at any time. It can be written only while an initialization request is high and its acknowledge, which follows the request one clock later, is also high. Standard-format frames use only the first two identifier bytes in the compare. Extended frames use all four.

Top module: `can_accept_filter`

## Requirements
- R1: After reset every code and mask register reads 0, and `rx_full`, `acc_pulse` and `init_ack` are 0.
- R2: `init_ack` takes the value `init_req` had at the previous rising clock edge.
- R3: A configuration write changes the addressed register only when `init_req` and `init_ack` are both 1 at the clock edge. Otherwise the register keeps its value.
- R4: `cfg_rdata` shows the addressed register combinationally at any time. Address map: `cfg_addr[3]` selects the mask (1) or the code (0), `cfg_addr[2]` selects the bank, and `cfg_addr[1:0]` = n selects byte IDRn, which is `frame_id[31-8n -: 8]`.
- R5: A mask bit of 1 makes the matching identifier bit a don't-care. A mask bit of 0 requires the identifier bit to equal the code bit.
- R6: For an extended frame (`frame_ide` = 1), all 32 identifier bits take part in the compare.
- R7: For a standard frame (`frame_ide` = 0), only IDR0 and IDR1 (`frame_id[31:16]`) are compared. `frame_id[15:0]` has no effect on the decision.
- R8: A frame is accepted when any bank matches. `hit_bank` reports the lowest-numbered matching bank.
- R9: Every strobed frame is stored in `bg_id`/`bg_ide` at the clock edge where `frame_valid` is sampled, whatever the filter result.
- R10: On an accepted frame, at the same edge, `rx_id`/`rx_ide` load the frame, `rx_full` becomes 1 and `acc_pulse` is 1 for one cycle. On a rejected frame, `acc_pulse` stays 0 and `rx_id` and `rx_full` are unchanged.
- R11: `rx_clr` = 1 clears `rx_full` at the next edge. If an accepted frame arrives at the same edge, `rx_full` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_req | input | 1 | Initialization request |
| init_ack | output | 1 | Initialization acknowledge, request delayed one clock |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the addressed register |
| frame_valid | input | 1 | Frame strobe |
| frame_ide | input | 1 | 1 = extended frame, 0 = standard frame |
| frame_id | input | 32 | Identifier bytes IDR0 (MSB) to IDR3 |
| bg_id | output | 32 | Background buffer identifier |
| bg_ide | output | 1 | Background buffer format bit |
| rx_clr | input | 1 | Write-one-to-clear for rx_full |
| rx_full | output | 1 | Host buffer holds an accepted frame |
| rx_id | output | 32 | Host buffer identifier |
| rx_ide | output | 1 | Host buffer format bit |
| acc_pulse | output | 1 | One-cycle pulse per accepted frame |
| hit_bank | output | 1 | Index of the bank that accepted the last frame |

## Verification
Extended frames are sent that differ from a code only in masked bits, and others that differ only in an unmasked low byte. Together they separate the don't-care behaviour from a full 32-bit compare. Standard frames with arbitrary low halves show that bytes IDR2 and IDR3 are ignored. Frames that hit only bank 1, and frames that hit both banks, check the bank priority. Writes made with the lock closed, and in the single cycle where the request is high but the acknowledge is not yet, separate a correct two-signal write gate from a gate that tests the request alone.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;
  localparam int ID_BYTES  = 4;
  localparam int STD_BYTES = 2;
  localparam int ID_W      = ID_BYTES * 8;

  // Care vector: bytes excluded by the frame format never count.
  function automatic logic [ID_W-1:0] care_bits(input logic [ID_W-1:0] mask,
                                                input logic ext);
    logic [ID_W-1:0] c;
    c = ~mask;
    for (int b = STD_BYTES; b < ID_BYTES; b++) begin
      if (!ext) c[(ID_BYTES-1-b)*8 +: 8] = 8'h00;
    end
    return c;
  endfunction

  function automatic logic id_match(input logic [ID_W-1:0] id,
                                    input logic [ID_W-1:0] code,
                                    input logic [ID_W-1:0] mask,
                                    input logic ext);
    return ((id ^ code) & care_bits(mask, ext)) == '0;
  endfunction
endpackage

// File: rtl/can_flt_regs.sv
module can_flt_regs
  import can_flt_pkg::*;
#(
  parameter int NB = 2,
  localparam int BANK_W = $clog2(NB),
  localparam int AW = 3 + BANK_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    init_req,
  output logic                    init_ack,
  input  logic                    cfg_we,
  input  logic [AW-1:0]           cfg_addr,
  input  logic [7:0]              cfg_wdata,
  output logic [7:0]              cfg_rdata,
  output logic [NB-1:0][ID_W-1:0] code_q,
  output logic [NB-1:0][ID_W-1:0] mask_q,
  output logic                    wr_open
);
  logic              sel_mask;
  logic [BANK_W-1:0] sel_bank;
  logic [1:0]        sel_byte;
  int                byte_lo;

  assign sel_mask = cfg_addr[AW-1];
  assign sel_bank = cfg_addr[2 +: BANK_W];
  assign sel_byte = cfg_addr[1:0];
  assign byte_lo  = (ID_BYTES - 1 - int'(sel_byte)) * 8;
  assign wr_open  = init_req & init_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_ack <= 1'b0;
      code_q   <= '0;
      mask_q   <= '0;
    end else begin
      init_ack <= init_req;
      if (cfg_we && wr_open) begin
        if (sel_mask) mask_q[sel_bank][byte_lo +: 8] <= cfg_wdata;
        else          code_q[sel_bank][byte_lo +: 8] <= cfg_wdata;
      end
    end
  end

  always_comb begin
    if (sel_mask) cfg_rdata = mask_q[sel_bank][byte_lo +: 8];
    else          cfg_rdata = code_q[sel_bank][byte_lo +: 8];
  end
endmodule

// File: rtl/can_flt_bank.sv
module can_flt_bank
  import can_flt_pkg::*;
(
  input  logic [ID_W-1:0] code,
  input  logic [ID_W-1:0] mask,
  input  logic [ID_W-1:0] frame_id,
  input  logic            frame_ide,
  output logic            hit
);
  assign hit = id_match(frame_id, code, mask, frame_ide);
endmodule

// File: rtl/can_flt_rxbuf.sv
module can_flt_rxbuf
  import can_flt_pkg::*;
#(
  parameter int HW = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_valid,
  input  logic            frame_ide,
  input  logic [ID_W-1:0] frame_id,
  input  logic            any_hit,
  input  logic [HW-1:0]   hit_idx,
  input  logic            rx_clr,
  output logic [ID_W-1:0] bg_id,
  output logic            bg_ide,
  output logic [ID_W-1:0] rx_id,
  output logic            rx_ide,
  output logic            rx_full,
  output logic            acc_pulse,
  output logic [HW-1:0]   hit_bank
);
  logic promote;
  assign promote = frame_valid & any_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bg_id     <= '0;
      bg_ide    <= 1'b0;
      rx_id     <= '0;
      rx_ide    <= 1'b0;
      rx_full   <= 1'b0;
      acc_pulse <= 1'b0;
      hit_bank  <= '0;
    end else begin
      acc_pulse <= promote;
      if (frame_valid) begin
        bg_id  <= frame_id;
        bg_ide <= frame_ide;
      end
      if (promote) begin
        rx_id    <= frame_id;
        rx_ide   <= frame_ide;
        hit_bank <= hit_idx;
        rx_full  <= 1'b1;
      end else if (rx_clr) begin
        rx_full  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_flt_pkg::*;
#(
  parameter int NB = 2,
  localparam int BANK_W = $clog2(NB),
  localparam int AW = 3 + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_req,
  output logic              init_ack,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              frame_valid,
  input  logic              frame_ide,
  input  logic [ID_W-1:0]   frame_id,
  output logic [ID_W-1:0]   bg_id,
  output logic              bg_ide,
  input  logic              rx_clr,
  output logic              rx_full,
  output logic [ID_W-1:0]   rx_id,
  output logic              rx_ide,
  output logic              acc_pulse,
  output logic [BANK_W-1:0] hit_bank
);
  logic [NB-1:0][ID_W-1:0] code_q;
  logic [NB-1:0][ID_W-1:0] mask_q;
  logic                    wr_open;
  logic [NB-1:0]           bank_hit;
  logic                    any_hit;
  logic [BANK_W-1:0]       hit_idx;

  can_flt_regs #(.NB(NB)) u_regs (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .code_q(code_q), .mask_q(mask_q), .wr_open(wr_open)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    can_flt_bank u_bank (
      .code(code_q[g]), .mask(mask_q[g]), .frame_id(frame_id),
      .frame_ide(frame_ide), .hit(bank_hit[g])
    );
  end

  assign any_hit = |bank_hit;

  // Lowest index wins.
  always_comb begin
    hit_idx = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (bank_hit[i]) hit_idx = BANK_W'(i);
    end
  end

  can_flt_rxbuf #(.HW(BANK_W)) u_rxbuf (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_ide(frame_ide),
    .frame_id(frame_id), .any_hit(any_hit), .hit_idx(hit_idx), .rx_clr(rx_clr),
    .bg_id(bg_id), .bg_ide(bg_ide), .rx_id(rx_id), .rx_ide(rx_ide),
    .rx_full(rx_full), .acc_pulse(acc_pulse), .hit_bank(hit_bank)
  );
endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk
  import can_flt_pkg::*;
#(
  parameter int NB = 2,
  localparam int BANK_W = $clog2(NB)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    init_req,
  input logic                    init_ack,
  input logic                    cfg_we,
  input logic                    frame_valid,
  input logic [ID_W-1:0]         frame_id,
  input logic                    rx_clr,
  input logic [ID_W-1:0]         rx_id,
  input logic                    rx_full,
  input logic                    acc_pulse,
  input logic [BANK_W-1:0]       hit_bank,
  input logic [ID_W-1:0]         bg_id,
  input logic                    any_hit,
  input logic [NB-1:0]           bank_hit,
  input logic [NB-1:0][ID_W-1:0] code_q,
  input logic [NB-1:0][ID_W-1:0] mask_q
);
  AST_ACK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |=> init_ack); // R2
  AST_ACK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !init_req |=> !init_ack); // R2
  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !(init_req && init_ack)) |=> ($stable(code_q) && $stable(mask_q))); // R3
  AST_BG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> (bg_id == $past(frame_id))); // R9
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !any_hit) |=> (!acc_pulse && $stable(rx_id))); // R10
  AST_FULL_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pulse |-> rx_full); // R10
  AST_BANK0_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && bank_hit[0]) |=> (hit_bank == '0)); // R8
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clr && !(frame_valid && any_hit)) |=> !rx_full); // R11
endmodule

bind can_accept_filter can_accept_filter_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
  .cfg_we(cfg_we), .frame_valid(frame_valid), .frame_id(frame_id),
  .rx_clr(rx_clr), .rx_id(rx_id), .rx_full(rx_full), .acc_pulse(acc_pulse),
  .hit_bank(hit_bank), .bg_id(bg_id), .any_hit(any_hit), .bank_hit(bank_hit),
  .code_q(code_q), .mask_q(mask_q)
);

// File: tb/can_accept_filter_bench.sv
module can_accept_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_req = 1'b0;
  logic        init_ack;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        frame_valid = 1'b0;
  logic        frame_ide = 1'b0;
  logic [31:0] frame_id = '0;
  logic [31:0] bg_id;
  logic        bg_ide;
  logic        rx_clr = 1'b0;
  logic        rx_full;
  logic [31:0] rx_id;
  logic        rx_ide;
  logic        acc_pulse;
  logic [0:0]  hit_bank;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] m_code [2];
  logic [31:0] m_mask [2];

  always #2.5 clk = ~clk;

  can_accept_filter u_can_accept_filter (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench restatement of the filter: a bit fails only if cared about and different.
  function automatic bit ref_hit(input int b, input logic [31:0] id, input bit ext);
    for (int k = 0; k < 32; k++) begin
      if (!ext && k < 16) continue;
      if (m_mask[b][k] == 1'b0 && id[k] != m_code[b][k]) return 0;
    end
    return 1;
  endfunction

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_lock(input bit open);
    @(negedge clk);
    init_req = open;
    @(negedge clk);
  endtask

  task automatic prog_bank(input int b, input logic [31:0] code, input logic [31:0] mask);
    for (int n = 0; n < 4; n++) begin
      wr(4'(b*4 + n), code[31-8*n -: 8]);
      wr(4'(8 + b*4 + n), mask[31-8*n -: 8]);
    end
    m_code[b] = code;
    m_mask[b] = mask;
  endtask

  task automatic clear_full();
    @(negedge clk); rx_clr = 1'b1;
    @(negedge clk); rx_clr = 1'b0;
    chk(rx_full == 1'b0, "R11 clear", 32'(rx_full), 0);
  endtask

  task automatic send(input logic [31:0] id, input bit ext, input string req);
    logic [31:0] old_id;
    bit h0, h1, acc;
    logic old_full;
    h0 = ref_hit(0, id, ext);
    h1 = ref_hit(1, id, ext);
    acc = h0 | h1;
    @(negedge clk);
    old_id = rx_id; old_full = rx_full;
    frame_valid = 1'b1; frame_id = id; frame_ide = ext;
    @(negedge clk);
    frame_valid = 1'b0;
    chk(bg_id == id && bg_ide == ext, {req, " R9 bg"}, bg_id, id);
    chk(acc_pulse == acc, {req, " R10 pulse"}, 32'(acc_pulse), 32'(acc));
    if (acc) begin
      chk(rx_id == id && rx_full, {req, " R10 promote"}, rx_id, id);
      chk(hit_bank == (h0 ? 1'b0 : 1'b1), {req, " R8 bank"}, 32'(hit_bank), h0 ? 0 : 1);
    end else begin
      chk(rx_id == old_id && rx_full == old_full, {req, " R10 reject"}, rx_id, old_id);
    end
    @(negedge clk);
    chk(acc_pulse == 1'b0, {req, " R10 one-cycle"}, 32'(acc_pulse), 0);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk(d == 8'h00, "R1 reg reset", 32'(d), 0);
    end
    chk(!rx_full && !acc_pulse && !init_ack, "R1 flags", {29'd0, rx_full, acc_pulse, init_ack}, 0);
  endtask

  task automatic t_lock();
    logic [7:0] d;
    wr(4'd0, 8'hA5);
    rd(4'd0, d);
    chk(d == 8'h00, "R3 locked write", 32'(d), 0);
    // Request rises with the write; acknowledge not yet high at that edge.
    @(negedge clk);
    init_req = 1'b1; cfg_we = 1'b1; cfg_addr = 4'd9; cfg_wdata = 8'h3C;
    chk(init_ack == 1'b0, "R2 ack low before edge", 32'(init_ack), 0);
    @(negedge clk);
    cfg_we = 1'b0;
    chk(init_ack == 1'b1, "R2 ack follows", 32'(init_ack), 1);
    rd(4'd9, d);
    chk(d == 8'h00, "R3 req-only write", 32'(d), 0);
    wr(4'd9, 8'h3C);
    rd(4'd9, d);
    chk(d == 8'h3C, "R3 open write", 32'(d), 8'h3C);
    wr(4'd9, 8'h00);
    set_lock(0);
    chk(init_ack == 1'b0, "R2 ack drops", 32'(init_ack), 0);
  endtask

  task automatic t_program();
    logic [7:0] d;
    set_lock(1);
    prog_bank(0, 32'h1234_5678, 32'h0000_00FF);
    prog_bank(1, 32'hABCD_0000, 32'h0000_FFFF);
    set_lock(0);
    for (int b = 0; b < 2; b++) begin
      for (int n = 0; n < 4; n++) begin
        rd(4'(b*4 + n), d);
        chk(d == m_code[b][31-8*n -: 8], "R4 code read", 32'(d), 32'(m_code[b][31-8*n -: 8]));
        rd(4'(8 + b*4 + n), d);
        chk(d == m_mask[b][31-8*n -: 8], "R4 mask read", 32'(d), 32'(m_mask[b][31-8*n -: 8]));
      end
    end
  endtask

  task automatic t_ext();
    send(32'h1234_56AB, 1'b1, "R5 R6 masked byte");
    clear_full();
    send(32'h1234_5778, 1'b1, "R6 byte2 differs");
    send(32'h0234_5678, 1'b1, "R5 unmasked bit");
    send(32'hABCD_1111, 1'b1, "R8 bank1 only");
    clear_full();
  endtask

  task automatic t_std();
    send(32'h1234_FFFF, 1'b0, "R7 low half ignored");
    send(32'hABCD_0055, 1'b0, "R7 bank1 std");
    send(32'h1235_5678, 1'b0, "R7 high half checked");
    clear_full();
  endtask

  task automatic t_prio_and_clear();
    logic [7:0] d;
    set_lock(1);
    prog_bank(1, 32'h0000_0000, 32'hFFFF_FFFF);
    set_lock(0);
    send(32'h1234_5699, 1'b1, "R8 both match");
    send(32'h9999_9999, 1'b1, "R8 only bank1");
    // Clear and accept at the same edge: set wins.
    @(negedge clk);
    rx_clr = 1'b1; frame_valid = 1'b1; frame_id = 32'h5555_0000; frame_ide = 1'b1;
    @(negedge clk);
    rx_clr = 1'b0; frame_valid = 1'b0;
    chk(rx_full == 1'b1, "R11 set wins", 32'(rx_full), 1);
    clear_full();
    wr(4'd0, 8'hFF);
    rd(4'd0, d);
    chk(d == 8'h12, "R3 relocked write", 32'(d), 8'h12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_program();
    t_ext();
    t_std();
    t_prio_and_clear();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule